// File: doc/BRIEF.md
# Descriptor Pointer Slot Sequencer

This block walks the pointer slots of a crypto-engine job descriptor, one slot at a time, in ascending slot order. A job starts on a one-cycle strobe, and the slot contents are captured into a local register file at that moment. Each slot carries a 32-bit address, a 16-bit length, an 8-bit extent and a jump flag. For each slot the sequencer picks one of four actions:
- A slot that is entirely zero is skipped.
- A slot with a zero address but other content hands its length and extent to an execution unit as literal values.
- A slot with an address and a clear jump flag issues one contiguous transfer request.
- A slot with an address and a set jump flag hands that address to a link table walker, and the sequencer then waits for the walker to report return.

When the last slot is finished, the block pulses a done strobe and returns to idle. If the walker reports an error while the sequencer waits on it, the job is abandoned. A sticky error flag replaces the done pulse, and the flag stays up until the next job is accepted. Fetching the descriptor, moving data and the execution units themselves are handled outside this block.

Top module: `desc_ptr_sequencer`

## Requirements
- R1: An accepted job handles slots 0 to 6 strictly in order, one at a time; `busy` is high from the cycle after the start strobe until the job ends; a start strobe while busy is ignored, and slot inputs that change after acceptance have no effect on the job.
- R2: A slot whose address, length, extent and jump flag are all zero takes exactly one cycle and raises none of `xfer_valid`, `eu_we` or `walk_start_valid`.
- R3: A slot with address zero that is not all zero (even with jump set) raises `eu_we` for exactly one cycle, with `eu_len`, `eu_ext` and `act_slot` carrying that slot's length, extent and index.
- R4: A slot with a nonzero address and jump 0 raises `xfer_valid` with `xfer_addr`/`xfer_len` equal to its address and length, held stable until `xfer_ready`; the next slot starts only after acceptance.
- R5: A slot with a nonzero address and jump 1 raises `walk_start_valid` with `walk_table_addr` held until `walk_start_ready`, then waits, with no action strobe, until `walk_return` before the next slot.
- R6: After slot 6 completes, `job_done` is high for exactly one cycle, and then `busy` falls.
- R7: `walk_error` while waiting on the walker ends the job at once with no `job_done`; `job_err` rises and stays high until the next job is accepted, which clears it.
- R8: Under reset all strobes, `busy` and `job_err` are low.
- R9: At most one of `xfer_valid`, `eu_we`, `walk_start_valid` and `job_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Start strobe; accepted only while idle |
| slot_ptr | input | 224 | Slot addresses, slot i at bits [32i+31:32i] |
| slot_len | input | 112 | Slot lengths, slot i at bits [16i+15:16i] |
| slot_ext | input | 56 | Slot extents, slot i at bits [8i+7:8i] |
| slot_jump | input | 7 | Jump flag per slot, slot i at bit i |
| xfer_valid | output | 1 | Contiguous transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | 32 | First byte address of the transfer |
| xfer_len | output | 16 | Transfer length |
| eu_we | output | 1 | Literal write strobe to the execution unit |
| eu_len | output | 16 | Literal length value |
| eu_ext | output | 8 | Literal extent value |
| act_slot | output | 3 | Index of the slot being handled |
| walk_start_valid | output | 1 | Link walk start request valid |
| walk_start_ready | input | 1 | Walker accepted the start |
| walk_table_addr | output | 32 | Address of the first link table |
| walk_return | input | 1 | Walker finished the chain |
| walk_error | input | 1 | Walker failed; aborts the job |
| job_done | output | 1 | One-cycle end-of-job pulse |
| job_err | output | 1 | Sticky abort flag |
| busy | output | 1 | A job is in progress |

## Verification
The bound checker checks on every cycle that the request handshakes hold address and length while they are stalled. It also checks that the action strobes are mutually exclusive, that the done pulse lasts one cycle and is followed by idle, that the error flag stays up until a new job starts, that an abort lands in idle with no done, and that literal writes never repeat for one slot. It cannot check the decision made for each slot, the slot order, how long a skip takes, or the values delivered. Those are shown only by the bench's behavioural model, which is driven with all-skip, all-literal, all-direct, all-link, mixed, abort and random jobs, with random handshake stalls and spurious start strobes.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [1:0] {
      K_SKIP   = 2'd0,
      K_LIT    = 2'd1,
      K_DIRECT = 2'd2,
      K_LINK   = 2'd3
   } slot_kind_e;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_EVAL   = 3'd1,
      S_XFER   = 3'd2,
      S_WSTART = 3'd3,
      S_WWAIT  = 3'd4,
      S_FINISH = 3'd5
   } dps_state_e;

endpackage

// File: rtl/dps_slot_file.sv
module dps_slot_file #(
   parameter int NUM_SLOTS = 7,
   parameter int PTR_W     = 32,
   parameter int LEN_W     = 16,
   parameter int EXT_W     = 8,
   parameter bit CAPTURE   = 1'b1,
   localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [NUM_SLOTS*PTR_W-1:0] in_ptr,
   input  logic [NUM_SLOTS*LEN_W-1:0] in_len,
   input  logic [NUM_SLOTS*EXT_W-1:0] in_ext,
   input  logic [NUM_SLOTS-1:0]       in_jump,
   input  logic [IDX_W-1:0]           sel,
   output logic [PTR_W-1:0]           cur_ptr,
   output logic [LEN_W-1:0]           cur_len,
   output logic [EXT_W-1:0]           cur_ext,
   output logic                       cur_jump
);

   logic [PTR_W-1:0] ptr_q [NUM_SLOTS];
   logic [LEN_W-1:0] len_q [NUM_SLOTS];
   logic [EXT_W-1:0] ext_q [NUM_SLOTS];
   logic             jmp_q [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (CAPTURE) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr_q[s] <= '0;
               len_q[s] <= '0;
               ext_q[s] <= '0;
               jmp_q[s] <= 1'b0;
            end else if (load) begin
               ptr_q[s] <= in_ptr[s*PTR_W +: PTR_W];
               len_q[s] <= in_len[s*LEN_W +: LEN_W];
               ext_q[s] <= in_ext[s*EXT_W +: EXT_W];
               jmp_q[s] <= in_jump[s];
            end
         end
      end else begin : g_wire
         assign ptr_q[s] = in_ptr[s*PTR_W +: PTR_W];
         assign len_q[s] = in_len[s*LEN_W +: LEN_W];
         assign ext_q[s] = in_ext[s*EXT_W +: EXT_W];
         assign jmp_q[s] = in_jump[s];
      end
   end

   always_comb begin
      cur_ptr  = '0;
      cur_len  = '0;
      cur_ext  = '0;
      cur_jump = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (sel == IDX_W'(s)) begin
            cur_ptr  = ptr_q[s];
            cur_len  = len_q[s];
            cur_ext  = ext_q[s];
            cur_jump = jmp_q[s];
         end
      end
   end

endmodule

// File: rtl/dps_classify.sv
module dps_classify
   import dps_pkg::*;
#(
   parameter int PTR_W = 32,
   parameter int LEN_W = 16,
   parameter int EXT_W = 8
) (
   input  logic [PTR_W-1:0] ptr,
   input  logic [LEN_W-1:0] len,
   input  logic [EXT_W-1:0] ext,
   input  logic             jump,
   output slot_kind_e       kind
);

   logic ptr_zero;
   logic rest_zero;

   assign ptr_zero  = (ptr == '0);
   assign rest_zero = (len == '0) && (ext == '0) && !jump;

   always_comb begin
      if (ptr_zero && rest_zero) kind = K_SKIP;
      else if (ptr_zero)         kind = K_LIT;
      else if (jump)             kind = K_LINK;
      else                       kind = K_DIRECT;
   end

endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
   import dps_pkg::*;
#(
   parameter int NUM_SLOTS = 7,
   localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             job_valid,
   input  slot_kind_e       kind,
   input  logic             xfer_ready,
   input  logic             walk_start_ready,
   input  logic             walk_return,
   input  logic             walk_error,
   output dps_state_e       state,
   output logic [IDX_W-1:0] slot_idx,
   output logic             load,
   output logic             err_flag
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

   dps_state_e       state_q, state_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             err_q, err_d;
   logic             step;

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      err_d   = err_q;
      step    = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (job_valid) begin
               state_d = S_EVAL;
               idx_d   = '0;
               err_d   = 1'b0;
            end
         end
         S_EVAL: begin
            case (kind)
               K_DIRECT: state_d = S_XFER;
               K_LINK:   state_d = S_WSTART;
               default:  step    = 1'b1;
            endcase
         end
         S_XFER:   step = xfer_ready;
         S_WSTART: if (walk_start_ready) state_d = S_WWAIT;
         S_WWAIT: begin
            if (walk_error) begin
               err_d   = 1'b1;
               state_d = S_IDLE;
            end else begin
               step = walk_return;
            end
         end
         S_FINISH: state_d = S_IDLE;
         default:  state_d = S_IDLE;
      endcase
      if (step) begin
         if (idx_q == LAST) begin
            state_d = S_FINISH;
         end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_EVAL;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         err_q   <= err_d;
      end
   end

   assign state    = state_q;
   assign slot_idx = idx_q;
   assign load     = (state_q == S_IDLE) && job_valid;
   assign err_flag = err_q;

endmodule

// File: rtl/desc_ptr_sequencer.sv
module desc_ptr_sequencer
   import dps_pkg::*;
#(
   parameter int NUM_SLOTS = 7,
   parameter int PTR_W     = 32,
   parameter int LEN_W     = 16,
   parameter int EXT_W     = 8,
   parameter bit CAPTURE   = 1'b1,
   localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       job_valid,
   input  logic [NUM_SLOTS*PTR_W-1:0] slot_ptr,
   input  logic [NUM_SLOTS*LEN_W-1:0] slot_len,
   input  logic [NUM_SLOTS*EXT_W-1:0] slot_ext,
   input  logic [NUM_SLOTS-1:0]       slot_jump,
   output logic                       xfer_valid,
   input  logic                       xfer_ready,
   output logic [PTR_W-1:0]           xfer_addr,
   output logic [LEN_W-1:0]           xfer_len,
   output logic                       eu_we,
   output logic [LEN_W-1:0]           eu_len,
   output logic [EXT_W-1:0]           eu_ext,
   output logic [IDX_W-1:0]           act_slot,
   output logic                       walk_start_valid,
   input  logic                       walk_start_ready,
   output logic [PTR_W-1:0]           walk_table_addr,
   input  logic                       walk_return,
   input  logic                       walk_error,
   output logic                       job_done,
   output logic                       job_err,
   output logic                       busy
);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("desc_ptr_sequencer: NUM_SLOTS must be at least 2");
   end
   if (PTR_W < 1 || LEN_W < 1 || EXT_W < 1) begin : g_bad_width
      $error("desc_ptr_sequencer: field widths must be positive");
   end

   dps_state_e       state;
   slot_kind_e       kind;
   logic [IDX_W-1:0] slot_idx;
   logic             load;
   logic [PTR_W-1:0] cur_ptr;
   logic [LEN_W-1:0] cur_len;
   logic [EXT_W-1:0] cur_ext;
   logic             cur_jump;

   dps_slot_file #(
      .NUM_SLOTS (NUM_SLOTS),
      .PTR_W     (PTR_W),
      .LEN_W     (LEN_W),
      .EXT_W     (EXT_W),
      .CAPTURE   (CAPTURE)
   ) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .in_ptr   (slot_ptr),
      .in_len   (slot_len),
      .in_ext   (slot_ext),
      .in_jump  (slot_jump),
      .sel      (slot_idx),
      .cur_ptr  (cur_ptr),
      .cur_len  (cur_len),
      .cur_ext  (cur_ext),
      .cur_jump (cur_jump)
   );

   dps_classify #(
      .PTR_W (PTR_W),
      .LEN_W (LEN_W),
      .EXT_W (EXT_W)
   ) u_cls (
      .ptr  (cur_ptr),
      .len  (cur_len),
      .ext  (cur_ext),
      .jump (cur_jump),
      .kind (kind)
   );

   dps_fsm #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_fsm (
      .clk              (clk),
      .rst_n            (rst_n),
      .job_valid        (job_valid),
      .kind             (kind),
      .xfer_ready       (xfer_ready),
      .walk_start_ready (walk_start_ready),
      .walk_return      (walk_return),
      .walk_error       (walk_error),
      .state            (state),
      .slot_idx         (slot_idx),
      .load             (load),
      .err_flag         (job_err)
   );

   assign busy             = (state != S_IDLE);
   assign xfer_valid       = (state == S_XFER);
   assign walk_start_valid = (state == S_WSTART);
   assign job_done         = (state == S_FINISH);
   assign eu_we            = (state == S_EVAL) && (kind == K_LIT);
   assign xfer_addr        = cur_ptr;
   assign xfer_len         = cur_len;
   assign walk_table_addr  = cur_ptr;
   assign eu_len           = cur_len;
   assign eu_ext           = cur_ext;
   assign act_slot         = slot_idx;

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
   parameter int NUM_SLOTS = 7,
   parameter int PTR_W     = 32,
   parameter int LEN_W     = 16,
   localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             job_valid,
   input logic             busy,
   input logic             xfer_valid,
   input logic             xfer_ready,
   input logic [PTR_W-1:0] xfer_addr,
   input logic [LEN_W-1:0] xfer_len,
   input logic             eu_we,
   input logic [IDX_W-1:0] act_slot,
   input logic             walk_start_valid,
   input logic             walk_start_ready,
   input logic [PTR_W-1:0] walk_table_addr,
   input logic             job_done,
   input logic             job_err
);

   assert_xfer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

   assert_walk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      walk_start_valid && !walk_start_ready |=> walk_start_valid && $stable(walk_table_addr));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      job_done |=> !job_done && !busy);

   assert_one_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_valid, eu_we, walk_start_valid, job_done}));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      job_err && !(job_valid && !busy) |=> job_err);

   assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(job_err) |-> !busy && !job_done);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !xfer_valid && !eu_we && !walk_start_valid && !job_done);

   assert_lit_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eu_we |=> !eu_we || (act_slot != $past(act_slot)));

endmodule

bind desc_ptr_sequencer dps_checker #(
   .NUM_SLOTS (NUM_SLOTS),
   .PTR_W     (PTR_W),
   .LEN_W     (LEN_W)
) u_dps_chk (.*);

// File: tb/test_desc_ptr_sequencer.sv
module test_desc_ptr_sequencer;

   localparam int NS = 7;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              job_valid = 1'b0;
   logic [NS*32-1:0]  slot_ptr = '0;
   logic [NS*16-1:0]  slot_len = '0;
   logic [NS*8-1:0]   slot_ext = '0;
   logic [NS-1:0]     slot_jump = '0;
   logic              xfer_ready = 1'b0;
   logic              walk_start_ready = 1'b0;
   logic              walk_return = 1'b0;
   logic              walk_error = 1'b0;
   logic              xfer_valid, eu_we, walk_start_valid, job_done, job_err, busy;
   logic [31:0]       xfer_addr, walk_table_addr;
   logic [15:0]       xfer_len, eu_len;
   logic [7:0]        eu_ext;
   logic [2:0]        act_slot;

   desc_ptr_sequencer i_desc_ptr_sequencer (.*);

   typedef struct {
      int          kind;
      logic [31:0] ptr;
      logic [15:0] len;
      logic [7:0]  ext;
      int          slot;
   } act_t;

   act_t mq[$];
   bit   m_busy, m_fin, m_err;
   int   m_phase;
   int   n_cmp = 0, n_bad = 0;
   bit   cmp_on = 1'b0;
   bit   kick = 1'b0, noise = 1'b0, err_force = 1'b0, hs_rand = 1'b1;

   // 0 skip, 1 literal, 2 direct, 3 link
   function automatic int kind_of(logic [31:0] p, logic [15:0] l, logic [7:0] e, logic j);
      if (p == 0 && l == 0 && e == 0 && !j) return 0;
      if (p == 0) return 1;
      if (j) return 3;
      return 2;
   endfunction

   task automatic check(string req, string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic pop_act();
      void'(mq.pop_front());
      m_phase = 0;
      if (mq.size() == 0) m_fin = 1'b1;
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_busy = 0; m_fin = 0; m_err = 0; m_phase = 0;
      end else if (!m_busy) begin
         if (job_valid) begin
            for (int s = 0; s < NS; s++) begin
               act_t a;
               a.ptr = slot_ptr[s*32 +: 32];
               a.len = slot_len[s*16 +: 16];
               a.ext = slot_ext[s*8 +: 8];
               a.kind = kind_of(a.ptr, a.len, a.ext, slot_jump[s]);
               a.slot = s;
               mq.push_back(a);
            end
            m_busy = 1; m_fin = 0; m_err = 0; m_phase = 0;
         end
      end else if (m_fin) begin
         m_busy = 0; m_fin = 0;
      end else begin
         case (m_phase)
            0: begin
               if (mq[0].kind == 2) m_phase = 1;
               else if (mq[0].kind == 3) m_phase = 2;
               else pop_act();
            end
            1: if (xfer_ready) pop_act();
            2: if (walk_start_ready) m_phase = 3;
            default: begin
               if (walk_error) begin
                  m_err = 1; m_busy = 0; mq.delete(); m_phase = 0;
               end else if (walk_return) begin
                  pop_act();
               end
            end
         endcase
      end
      cmp_on = 1'b1;
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         bit e_eu, e_x, e_w, e_d;
         e_eu = 0; e_x = 0; e_w = 0; e_d = 0;
         if (m_busy && m_fin) e_d = 1;
         else if (m_busy) begin
            e_eu = (m_phase == 0) && (mq[0].kind == 1);
            e_x  = (m_phase == 1);
            e_w  = (m_phase == 2);
         end
         check("R1", "busy", busy, m_busy);
         check("R6", "job_done", job_done, e_d);
         check("R7", "job_err", job_err, m_err);
         check("R3", "eu_we", eu_we, e_eu);
         check("R4", "xfer_valid", xfer_valid, e_x);
         check("R5", "walk_start_valid", walk_start_valid, e_w);
         if (e_eu) begin
            check("R3", "eu_len", eu_len, mq[0].len);
            check("R3", "eu_ext", eu_ext, mq[0].ext);
            check("R3", "act_slot", act_slot, mq[0].slot);
         end
         if (e_x) begin
            check("R4", "xfer_addr", xfer_addr, mq[0].ptr);
            check("R4", "xfer_len", xfer_len, mq[0].len);
            check("R4", "act_slot", act_slot, mq[0].slot);
         end
         if (e_w) begin
            check("R5", "walk_table_addr", walk_table_addr, mq[0].ptr);
            check("R5", "act_slot", act_slot, mq[0].slot);
         end
         if (m_busy && m_phase == 3)
            check("R5", "wait quiet", {xfer_valid, eu_we, walk_start_valid}, 0);
      end
      xfer_ready       <= hs_rand ? 1'($urandom % 2) : 1'b1;
      walk_start_ready <= hs_rand ? 1'($urandom % 2) : 1'b1;
      walk_return      <= hs_rand ? 1'($urandom % 3 == 0) : 1'b1;
      walk_error       <= err_force;
      job_valid        <= kick | (noise & m_busy & 1'($urandom % 4 == 0));
   end

   task automatic set_slot(int s, int k);
      logic [31:0] p;
      p = $urandom | 32'h1;
      case (k)
         0: begin slot_ptr[s*32 +: 32] = 0; slot_len[s*16 +: 16] = 0;
                  slot_ext[s*8 +: 8] = 0; slot_jump[s] = 0; end
         1: begin slot_ptr[s*32 +: 32] = 0; slot_len[s*16 +: 16] = 16'($urandom);
                  slot_ext[s*8 +: 8] = 8'($urandom | 1); slot_jump[s] = 1'($urandom); end
         2: begin slot_ptr[s*32 +: 32] = p; slot_len[s*16 +: 16] = 16'($urandom);
                  slot_ext[s*8 +: 8] = 8'($urandom); slot_jump[s] = 0; end
         default: begin slot_ptr[s*32 +: 32] = p; slot_len[s*16 +: 16] = 16'($urandom);
                  slot_ext[s*8 +: 8] = 8'($urandom); slot_jump[s] = 1; end
      endcase
   endtask

   task automatic run_job();
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      @(negedge clk);
      // R1: inputs changed after acceptance must not affect the job
      for (int s = 0; s < NS; s++) set_slot(s, $urandom % 4);
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int done_seen, acts;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      check("R8", "outputs in reset", {xfer_valid, eu_we, walk_start_valid, job_done, job_err, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: all-skip job: 1 accept edge, 7 eval cycles, finish cycle
      for (int s = 0; s < NS; s++) set_slot(s, 0);
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      done_seen = -1; acts = 0;
      for (int c = 0; c < 12; c++) begin
         if (xfer_valid || eu_we || walk_start_valid) acts++;
         if (job_done && done_seen < 0) done_seen = c;
         @(negedge clk);
      end
      check("R2", "actions in all-skip job", acts, 0);
      check("R2", "cycle of done in all-skip job", done_seen, 7);

      for (int s = 0; s < NS; s++) set_slot(s, 1); run_job();   // R3
      for (int s = 0; s < NS; s++) set_slot(s, 2); run_job();   // R4
      for (int s = 0; s < NS; s++) set_slot(s, 3); run_job();   // R5
      for (int s = 0; s < NS; s++) set_slot(s, s % 4);
      slot_ptr[0 +: 32] = 0; slot_len[0 +: 16] = 0; slot_ext[0 +: 8] = 0; slot_jump[0] = 1;
      run_job();                                                 // R3 zero literal with jump

      // R7: abort on walker error, then clear on next job
      for (int s = 0; s < NS; s++) set_slot(s, 2);
      set_slot(2, 3);
      err_force = 1'b1;
      done_seen = 0;
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      while (busy) begin
         if (job_done) done_seen++;
         @(negedge clk);
      end
      err_force = 1'b0;
      check("R7", "done during aborted job", done_seen, 0);
      check("R7", "job_err after abort", job_err, 1);
      repeat (3) @(negedge clk);
      check("R7", "job_err sticky", job_err, 1);
      for (int s = 0; s < NS; s++) set_slot(s, 1);
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      check("R7", "job_err cleared by new job", job_err, 0);
      while (m_busy) @(negedge clk);

      // R1/R9: random jobs with stalls and spurious start strobes
      noise = 1'b1;
      for (int j = 0; j < 60; j++) begin
         hs_rand = (j % 5 != 0);
         for (int s = 0; s < NS; s++) set_slot(s, $urandom % 4);
         run_job();
      end
      noise = 1'b0;
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule